// File: doc/BRIEF.md
# PSRAM Configuration Register Access Unit

This block sits on the device side of a pseudo-SRAM array, behind a multiplexed address/data bus with active-low address-valid, chip-enable, write-enable, output-enable and two byte-lane strobes. It holds two 16-bit configuration registers, one for bus settings and one for refresh settings, and lets the host reach them in two ways. The first way uses a dedicated register-select pin: while it is high, an ordinary bus cycle is steered to a register instead of the array. The second way is a four-cycle unlock sequence aimed at the highest array address. This sequence works at either level of the select pin.

Every bus pin is sampled into a register on the block clock. Edges are found by comparing the last two samples. Cycles that do not target a register pass through to the array as a read level or a write pulse, carrying the latched address, the data and the byte enables. In the read path, the array's returned data goes back out through the block.

Top module: `psram_cfg_unit`

## Requirements
- R1: After reset, the refresh register reads 0x0010 and the bus register reads 0x9D1F.
- R2: With the select pin high, a write cycle loads bus bits [15:0] into the register chosen by address bits [19:18]: 00 picks the refresh register and 01 picks the bus register. The byte-lane strobes have no effect on this write.
- R3: With the select pin high, codes 10 and 11 in address bits [19:18] change neither register, and a read with such a code returns 0x0000.
- R4: A register read drives all 16 bits of the chosen register on dq_out, with dq_oe high.
- R5: A pin-selected write takes the bus value present at the first rising edge among address-valid, chip-enable and write-enable. Any later change within the same cycle is not captured.
- R6: With the select pin low, a write cycle emits one arr_wr pulse carrying the latched address, the write data and the active-high byte enables {~ub_n, ~lb_n}. The registers do not change.
- R7: With the select pin low, a read cycle returns arr_rdata on dq_out.
- R8: The unlock sequence is two reads, then a write of 0x0000 (refresh) or 0x0001 (bus), then a fourth cycle. All four cycles go to the all-ones address. When the fourth cycle is a read, it returns the chosen register.
- R9: When the fourth unlock cycle is a write, it loads the chosen register. If that register is the refresh register, bit 4 (deep power-down) keeps its old value.
- R10: A third-cycle value other than 0x0000 or 0x0001 aborts the sequence, so the next access to the all-ones address goes to the array.
- R11: A cycle to any other address in the middle of the sequence resets it to idle, and that cycle is handled as an array access.
- R12: A cycle flagged synchronous (sync_cyc high) never advances the sequence and returns it to idle.
- R13: The unlock sequence works the same way while the select pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sel | input | 1 | High: the cycle targets a configuration register |
| sync_cyc | input | 1 | High: the cycle is a synchronous (burst) access |
| adv_n | input | 1 | Address valid, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low byte strobe, active low |
| ub_n | input | 1 | High byte strobe, active low |
| ahi | input | AW-16 | Upper address bits |
| dq_in | input | 16 | Multiplexed address/data, inbound |
| dq_out | output | 16 | Read data, outbound |
| dq_oe | output | 1 | dq_out is driven |
| arr_rd | output | 1 | Array read in progress |
| arr_wr | output | 1 | One-clock array write pulse |
| arr_addr | output | AW | Latched cycle address for the array |
| arr_wdata | output | 16 | Array write data |
| arr_be | output | 2 | Array byte enables, active high |
| arr_rdata | input | 16 | Data returned by the array |

## Verification
Each pin change lands in the sample register at the next clock edge. A register write, an array write pulse, and the dq_out/dq_oe read result all follow one edge after that. So any result is settled two edges after the stimulus pin moves. The bench holds every bus phase for at least two clocks and usually four. It changes pins and samples outputs on the falling edge, and reads dq_out only after output-enable has been low for four clocks. Register contents are always observed through a later read cycle, never at a fixed edge. Array write pulses are collected by a falling-edge monitor and compared as counts and captured fields.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int DW = 16;

  typedef enum logic [1:0] {TGT_NONE, TGT_RCR, TGT_BCR} tgt_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD1,
    SQ_RD2,
    SQ_ARM_RCR,
    SQ_ARM_BCR
  } seq_t;

  // pin-path register select code
  function automatic tgt_t pin_target(input logic [1:0] code);
    case (code)
      2'b00:   return TGT_RCR;
      2'b01:   return TGT_BCR;
      default: return TGT_NONE;
    endcase
  endfunction

  // third-cycle selector of the unlock path
  function automatic tgt_t unlock_target(input logic [DW-1:0] d);
    if (d == 16'h0000) return TGT_RCR;
    if (d == 16'h0001) return TGT_BCR;
    return TGT_NONE;
  endfunction

  // software write keeps the protected bit of the old value
  function automatic logic [DW-1:0] guard_merge(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] new_v,
                                                input int unsigned   bit_idx);
    logic [DW-1:0] m;
    m = '0;
    m[bit_idx] = 1'b1;
    return (new_v & ~m) | (old_v & m);
  endfunction

  function automatic logic [DW-1:0] reg_pick(input tgt_t t,
                                             input logic [DW-1:0] rcr,
                                             input logic [DW-1:0] bcr);
    case (t)
      TGT_RCR: return rcr;
      TGT_BCR: return bcr;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pcu_bus_sampler.sv
module pcu_bus_sampler #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic          sync_cyc,
  input  logic          adv_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic [AW-DW-1:0] ahi,
  input  logic [DW-1:0] dq_in,
  output logic          addr_ph,
  output logic [AW-1:0] bus_now,
  output logic [AW-1:0] bus_prev,
  output logic          sync_now,
  output logic [AW-1:0] adr_lat,
  output logic          cre_lat,
  output logic          sync_lat,
  output logic [1:0]    lanes_prev,
  output logic          cyc_end,
  output logic          wr_end,
  output logic          first_rise_wr,
  output logic          rd_act,
  output logic          cyc_is_wr
);

  logic p_adv, p_ce, p_we, p_oe, q_adv, q_ce, q_we;
  logic cre_now;
  logic [1:0] lanes_now;
  logic rise_adv, rise_ce, rise_we, fall_ce;
  logic first_done, wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_adv <= 1'b1; p_ce <= 1'b1; p_we <= 1'b1; p_oe <= 1'b1;
      q_adv <= 1'b1; q_ce <= 1'b1; q_we <= 1'b1;
      bus_now <= '0; bus_prev <= '0;
      cre_now <= 1'b0; sync_now <= 1'b0;
      lanes_now <= 2'b11; lanes_prev <= 2'b11;
    end else begin
      p_adv <= adv_n; p_ce <= ce_n; p_we <= we_n; p_oe <= oe_n;
      q_adv <= p_adv; q_ce <= p_ce; q_we <= p_we;
      bus_now <= {ahi, dq_in};
      bus_prev <= bus_now;
      cre_now <= cfg_sel;
      sync_now <= sync_cyc;
      lanes_now <= {ub_n, lb_n};
      lanes_prev <= lanes_now;
    end
  end

  assign rise_adv = p_adv & ~q_adv;
  assign rise_ce  = p_ce & ~q_ce;
  assign rise_we  = p_we & ~q_we;
  assign fall_ce  = ~p_ce & q_ce;

  assign addr_ph = ~p_ce & ~p_adv;
  assign cyc_end = rise_ce;
  assign rd_act  = ~p_ce & ~p_oe & p_we;
  assign wr_end  = (rise_we & ~q_ce) | (rise_ce & ~q_we);
  assign first_rise_wr = (rise_adv | rise_we | rise_ce) & ~q_ce & ~q_we & ~first_done;
  assign cyc_is_wr = wr_seen | ~q_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_lat <= '0;
      cre_lat <= 1'b0;
      sync_lat <= 1'b0;
      first_done <= 1'b0;
      wr_seen <= 1'b0;
    end else begin
      if (addr_ph) begin
        adr_lat <= bus_now;
        cre_lat <= cre_now;
        sync_lat <= sync_now;
      end
      if (fall_ce)
        first_done <= 1'b0;
      else if ((rise_adv | rise_we | rise_ce) & ~q_ce)
        first_done <= 1'b1;
      if (fall_ce)
        wr_seen <= 1'b0;
      else if (~q_we & ~q_ce)
        wr_seen <= 1'b1;
    end
  end

  // R5
  first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_rise_wr |=> !first_rise_wr);

endmodule

// File: rtl/pcu_unlock.sv
module pcu_unlock
  import pcu_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ph,
  input  logic [AW-1:0] bus_now,
  input  logic          sync_now,
  input  logic [AW-1:0] adr_lat,
  input  logic          sync_lat,
  input  logic          cyc_end,
  input  logic          cyc_is_wr,
  input  logic          wr_end,
  input  logic [DW-1:0] wdata,
  output logic          sw_hit,
  output tgt_t          sw_tgt,
  output seq_t          seq_st
);

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  seq_t          nxt;
  logic [DW-1:0] sel_d, sel_now;
  logic          armed, at_top;
  tgt_t          arm_tgt;

  assign armed   = (seq_st == SQ_ARM_RCR) || (seq_st == SQ_ARM_BCR);
  assign arm_tgt = (seq_st == SQ_ARM_RCR) ? TGT_RCR :
                   (seq_st == SQ_ARM_BCR) ? TGT_BCR : TGT_NONE;
  assign at_top  = (adr_lat == TOP_ADDR);
  assign sel_now = wr_end ? wdata : sel_d;

  always_comb begin
    nxt = SQ_IDLE;
    if (at_top && !sync_lat) begin
      case (seq_st)
        SQ_IDLE: nxt = cyc_is_wr ? SQ_IDLE : SQ_RD1;
        SQ_RD1:  nxt = cyc_is_wr ? SQ_IDLE : SQ_RD2;
        SQ_RD2: begin
          if (!cyc_is_wr) nxt = SQ_RD2;
          else begin
            case (unlock_target(sel_now))
              TGT_RCR: nxt = SQ_ARM_RCR;
              TGT_BCR: nxt = SQ_ARM_BCR;
              default: nxt = SQ_IDLE;
            endcase
          end
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_st <= SQ_IDLE;
      sel_d  <= '0;
      sw_hit <= 1'b0;
      sw_tgt <= TGT_NONE;
    end else begin
      if (wr_end) sel_d <= wdata;
      if (addr_ph) begin
        sw_hit <= armed && (bus_now == TOP_ADDR) && !sync_now;
        sw_tgt <= arm_tgt;
      end else if (cyc_end) begin
        sw_hit <= 1'b0;
      end
      if (cyc_end) seq_st <= nxt;
    end
  end

  // R11
  seq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !at_top) |=> (seq_st == SQ_IDLE));

  // R12
  sync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && sync_lat) |=> (seq_st == SQ_IDLE));

endmodule

// File: rtl/pcu_regs.sv
module pcu_regs
  import pcu_pkg::*;
#(
  parameter logic [15:0] RCR_INIT = 16'h0010,
  parameter logic [15:0] BCR_INIT = 16'h9D1F,
  parameter int unsigned GUARD_BIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_we,
  input  tgt_t        pin_tgt,
  input  logic [15:0] pin_val,
  input  logic        sw_we,
  input  tgt_t        sw_tgt,
  input  logic [15:0] sw_val,
  output logic [15:0] rcr_q,
  output logic [15:0] bcr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcr_q <= RCR_INIT;
      bcr_q <= BCR_INIT;
    end else if (sw_we) begin
      if (sw_tgt == TGT_RCR) rcr_q <= guard_merge(rcr_q, sw_val, GUARD_BIT);
      if (sw_tgt == TGT_BCR) bcr_q <= sw_val;
    end else if (pin_we) begin
      if (pin_tgt == TGT_RCR) rcr_q <= pin_val;
      if (pin_tgt == TGT_BCR) bcr_q <= pin_val;
    end
  end

  // R9
  dpd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && sw_tgt == TGT_RCR) |=> (rcr_q[GUARD_BIT] == $past(rcr_q[GUARD_BIT])));

  // R3
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_we && !sw_we && pin_tgt == TGT_NONE) |=> ($stable(rcr_q) && $stable(bcr_q)));

endmodule

// File: rtl/psram_cfg_unit.sv
module psram_cfg_unit
  import pcu_pkg::*;
#(
  parameter int          AW       = 22,
  parameter int          SEL_LSB  = 18,
  parameter logic [15:0] RCR_INIT = 16'h0010,
  parameter logic [15:0] BCR_INIT = 16'h9D1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sel,
  input  logic             sync_cyc,
  input  logic             adv_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             lb_n,
  input  logic             ub_n,
  input  logic [AW-17:0]   ahi,
  input  logic [15:0]      dq_in,
  output logic [15:0]      dq_out,
  output logic             dq_oe,
  output logic             arr_rd,
  output logic             arr_wr,
  output logic [AW-1:0]    arr_addr,
  output logic [15:0]      arr_wdata,
  output logic [1:0]       arr_be,
  input  logic [15:0]      arr_rdata
);

  logic          addr_ph, sync_now, cre_lat, sync_lat;
  logic [AW-1:0] bus_now, bus_prev, adr_lat;
  logic [1:0]    lanes_prev;
  logic          cyc_end, wr_end, first_rise_wr, rd_act, cyc_is_wr;
  logic          sw_hit;
  tgt_t          sw_tgt;
  seq_t          seq_st;
  logic [15:0]   rcr_q, bcr_q;
  logic          pin_wr_ev, sw_wr_ev, arr_wr_ev;
  tgt_t          pin_wr_tgt, pin_rd_tgt;

  pcu_bus_sampler #(.AW(AW), .DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .sync_cyc(sync_cyc),
    .adv_n(adv_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .ahi(ahi), .dq_in(dq_in),
    .addr_ph(addr_ph), .bus_now(bus_now), .bus_prev(bus_prev),
    .sync_now(sync_now), .adr_lat(adr_lat), .cre_lat(cre_lat),
    .sync_lat(sync_lat), .lanes_prev(lanes_prev), .cyc_end(cyc_end),
    .wr_end(wr_end), .first_rise_wr(first_rise_wr), .rd_act(rd_act),
    .cyc_is_wr(cyc_is_wr)
  );

  pcu_unlock #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr_ph(addr_ph), .bus_now(bus_now),
    .sync_now(sync_now), .adr_lat(adr_lat), .sync_lat(sync_lat),
    .cyc_end(cyc_end), .cyc_is_wr(cyc_is_wr), .wr_end(wr_end),
    .wdata(bus_prev[DW-1:0]), .sw_hit(sw_hit), .sw_tgt(sw_tgt),
    .seq_st(seq_st)
  );

  assign pin_wr_tgt = pin_target(bus_prev[SEL_LSB+1:SEL_LSB]);
  assign pin_rd_tgt = pin_target(adr_lat[SEL_LSB+1:SEL_LSB]);
  assign pin_wr_ev  = first_rise_wr & cre_lat & ~sw_hit;
  assign sw_wr_ev   = wr_end & sw_hit;
  assign arr_wr_ev  = wr_end & ~cre_lat & ~sw_hit;

  pcu_regs #(.RCR_INIT(RCR_INIT), .BCR_INIT(BCR_INIT), .GUARD_BIT(4)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .pin_we(pin_wr_ev), .pin_tgt(pin_wr_tgt), .pin_val(bus_prev[DW-1:0]),
    .sw_we(sw_wr_ev), .sw_tgt(sw_tgt), .sw_val(bus_prev[DW-1:0]),
    .rcr_q(rcr_q), .bcr_q(bcr_q)
  );

  assign arr_addr = adr_lat;
  assign arr_rd   = rd_act & ~cre_lat & ~sw_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_wr    <= 1'b0;
      arr_wdata <= '0;
      arr_be    <= 2'b00;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
    end else begin
      arr_wr <= arr_wr_ev;
      if (arr_wr_ev) begin
        arr_wdata <= bus_prev[DW-1:0];
        arr_be    <= ~lanes_prev;
      end
      dq_oe <= rd_act;
      if (sw_hit)       dq_out <= reg_pick(sw_tgt, rcr_q, bcr_q);
      else if (cre_lat) dq_out <= reg_pick(pin_rd_tgt, rcr_q, bcr_q);
      else              dq_out <= arr_rdata;
    end
  end

  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_wr_ev, sw_wr_ev, pin_wr_ev}));

  // R8
  arr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_ev || pin_wr_ev) |=> !arr_wr);

endmodule

// File: tb/psram_cfg_unit_test.sv
module psram_cfg_unit_test;

  localparam int AW = 22;
  localparam logic [AW-1:0] TOPA = {AW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel = 1'b0, sync_cyc = 1'b0;
  logic adv_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-17:0] ahi = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, arr_wdata, arr_rdata;
  logic dq_oe, arr_rd, arr_wr;
  logic [AW-1:0] arr_addr;
  logic [1:0] arr_be;

  int total = 0, bad = 0;
  int wr_cnt = 0;
  logic [AW-1:0] last_wa;
  logic [15:0] last_wd;
  logic [1:0] last_be;
  logic [15:0] rcr_m = 16'h0010, bcr_m = 16'h9D1F;

  always #2 clk = ~clk;

  psram_cfg_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .sync_cyc(sync_cyc),
    .adv_n(adv_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .ahi(ahi), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_be(arr_be), .arr_rdata(arr_rdata)
  );

  function automatic logic [15:0] arr_model(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C ^ {10'd0, a[AW-1:16]};
  endfunction
  assign arr_rdata = arr_model(arr_addr);

  function automatic logic [15:0] keep_dpd(input logic [15:0] o, input logic [15:0] n);
    return {n[15:5], o[4], n[3:0]};
  endfunction

  always @(negedge clk) begin
    if (arr_wr) begin
      wr_cnt++;
      last_wa = arr_addr; last_wd = arr_wdata; last_be = arr_be;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic cre, input logic syn, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [1:0] ben);
    @(negedge clk);
    cfg_sel = cre; sync_cyc = syn; {ahi, dq_in} = a; {ub_n, lb_n} = ben;
    ce_n = 1'b0; adv_n = 1'b0; we_n = ~cre;
    hold(4); adv_n = 1'b1;
    hold(4); we_n = 1'b1;
    hold(2); dq_in = d; we_n = 1'b0;
    hold(4); we_n = 1'b1;
    hold(4); ce_n = 1'b1; {ub_n, lb_n} = 2'b11;
    hold(4);
  endtask

  task automatic bread(input logic cre, input logic syn, input logic [AW-1:0] a,
                       output logic [15:0] v, output logic oe);
    @(negedge clk);
    cfg_sel = cre; sync_cyc = syn; {ahi, dq_in} = a;
    ce_n = 1'b0; adv_n = 1'b0; we_n = 1'b1;
    hold(4); adv_n = 1'b1;
    hold(2); oe_n = 1'b0;
    hold(4); v = dq_out; oe = dq_oe;
    oe_n = 1'b1;
    hold(4); ce_n = 1'b1;
    hold(4);
  endtask

  function automatic logic [AW-1:0] pin_addr(input logic [1:0] code, input logic [15:0] val);
    logic [AW-1:0] a;
    a = '0;
    a[19:18] = code;
    a[15:0] = val;
    return a;
  endfunction

  task automatic pin_rd_chk(input string req, input logic [1:0] code, input logic [15:0] exp);
    logic [15:0] v; logic oe;
    bread(1'b1, 1'b0, pin_addr(code, 16'h0), v, oe);
    chk(req, {15'd0, oe, v}, {15'd0, 1'b1, exp});
  endtask

  task automatic arr_rd_chk(input string req, input logic [AW-1:0] a);
    logic [15:0] v; logic oe;
    bread(1'b0, 1'b0, a, v, oe);
    chk(req, {15'd0, oe, v}, {15'd0, 1'b1, arr_model(a)});
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v; logic oe;
    void'($urandom(32'h0000BEE5));
    hold(3); rst_n = 1'b1; hold(2);

    // R1 reset defaults, R4 full-width read
    pin_rd_chk("R1 rcr", 2'b00, 16'h0010);
    pin_rd_chk("R1 bcr", 2'b01, 16'h9D1F);
    chk("R4 idle dq_oe", {31'd0, dq_oe}, 32'd0);

    // R2 pin writes, strobes inactive / mixed
    bwrite(1'b1, 1'b0, pin_addr(2'b00, 16'h1234), 16'h7777, 2'b11); rcr_m = 16'h1234;
    arr_rd_chk("R7 after reg op", 22'h012345);
    bwrite(1'b1, 1'b0, pin_addr(2'b01, 16'hBEEF), 16'h0000, 2'b10); bcr_m = 16'hBEEF;
    pin_rd_chk("R2 rcr", 2'b00, rcr_m);
    pin_rd_chk("R2 R4 bcr", 2'b01, bcr_m);

    // R3 reserved codes
    bwrite(1'b1, 1'b0, pin_addr(2'b10, 16'hAAAA), 16'h0, 2'b00);
    bwrite(1'b1, 1'b0, pin_addr(2'b11, 16'h5555), 16'h0, 2'b00);
    pin_rd_chk("R3 rcr kept", 2'b00, rcr_m);
    pin_rd_chk("R3 bcr kept", 2'b01, bcr_m);
    pin_rd_chk("R3 rsvd read", 2'b10, 16'h0000);

    // R5 first rising edge captures
    @(negedge clk);
    cfg_sel = 1'b1; sync_cyc = 1'b0; {ahi, dq_in} = pin_addr(2'b00, 16'h0F0F);
    ce_n = 1'b0; adv_n = 1'b0; we_n = 1'b0;
    hold(4); we_n = 1'b1;
    hold(4); dq_in = 16'hF0F0;
    hold(4); adv_n = 1'b1;
    hold(4); ce_n = 1'b1;
    hold(4);
    rcr_m = 16'h0F0F;
    pin_rd_chk("R5 first edge", 2'b00, rcr_m);

    // R6 array write
    begin
      int c0; c0 = wr_cnt;
      bwrite(1'b0, 1'b0, 22'h0A1B2C, 16'hC3D4, 2'b10);
      chk("R6 pulse count", wr_cnt - c0, 1);
      chk("R6 addr", {10'd0, last_wa}, {10'd0, 22'h0A1B2C});
      chk("R6 data", {16'd0, last_wd}, {16'd0, 16'hC3D4});
      chk("R6 be", {30'd0, last_be}, {30'd0, 2'b01});
      pin_rd_chk("R6 regs untouched", 2'b00, rcr_m);
    end

    // R8 unlock read of both registers
    bread(1'b0, 1'b0, TOPA, v, oe); bread(1'b0, 1'b0, TOPA, v, oe);
    bwrite(1'b0, 1'b0, TOPA, 16'h0000, 2'b00);
    bread(1'b0, 1'b0, TOPA, v, oe);
    chk("R8 sw read rcr", {16'd0, v}, {16'd0, rcr_m});
    arr_rd_chk("R7 after sw op", 22'h001111);
    bread(1'b0, 1'b0, TOPA, v, oe); bread(1'b0, 1'b0, TOPA, v, oe);
    bwrite(1'b0, 1'b0, TOPA, 16'h0001, 2'b00);
    bread(1'b0, 1'b0, TOPA, v, oe);
    chk("R8 sw read bcr", {16'd0, v}, {16'd0, bcr_m});

    // R9 unlock write, deep power-down bit protected
    bread(1'b0, 1'b0, TOPA, v, oe); bread(1'b0, 1'b0, TOPA, v, oe);
    bwrite(1'b0, 1'b0, TOPA, 16'h0000, 2'b00);
    begin
      int c0; c0 = wr_cnt;
      bwrite(1'b0, 1'b0, TOPA, 16'hFFFF, 2'b00);
      chk("R9 no array pulse", wr_cnt - c0, 0);
    end
    rcr_m = keep_dpd(rcr_m, 16'hFFFF);
    pin_rd_chk("R9 rcr guarded", 2'b00, rcr_m);
    bread(1'b0, 1'b0, TOPA, v, oe); bread(1'b0, 1'b0, TOPA, v, oe);
    bwrite(1'b0, 1'b0, TOPA, 16'h0001, 2'b00);
    bwrite(1'b0, 1'b0, TOPA, 16'h1357, 2'b00);
    bcr_m = 16'h1357;
    pin_rd_chk("R9 bcr written", 2'b01, bcr_m);

    // R10 bad selector aborts
    bread(1'b0, 1'b0, TOPA, v, oe); bread(1'b0, 1'b0, TOPA, v, oe);
    bwrite(1'b0, 1'b0, TOPA, 16'h0002, 2'b00);
    arr_rd_chk("R10 abort", TOPA);

    // R11 foreign address mid-sequence
    bread(1'b0, 1'b0, TOPA, v, oe); bread(1'b0, 1'b0, TOPA, v, oe);
    arr_rd_chk("R11 foreign goes to array", 22'h02AAAA);
    bwrite(1'b0, 1'b0, TOPA, 16'h0001, 2'b00);
    arr_rd_chk("R11 sequence reset", TOPA);

    // R12 synchronous cycle breaks sequence
    bread(1'b0, 1'b1, TOPA, v, oe); bread(1'b0, 1'b0, TOPA, v, oe);
    bwrite(1'b0, 1'b0, TOPA, 16'h0000, 2'b00);
    arr_rd_chk("R12 sync not counted", TOPA);

    // R13 sequence with select pin high
    bread(1'b1, 1'b0, TOPA, v, oe); bread(1'b1, 1'b0, TOPA, v, oe);
    bwrite(1'b1, 1'b0, TOPA, 16'h0001, 2'b00);
    bread(1'b1, 1'b0, TOPA, v, oe);
    chk("R13 sw read with pin high", {16'd0, v}, {16'd0, bcr_m});
    pin_rd_chk("R13 regs intact", 2'b00, rcr_m);

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [AW-1:0] a;
      logic [15:0] d;
      int op;
      op = $urandom % 4;
      a = AW'($urandom);
      a[21] = 1'b0;
      d = 16'($urandom);
      case (op)
        0: begin
          bwrite(1'b1, 1'b0, a, d, 2'($urandom));
          case (a[19:18])
            2'b00: rcr_m = a[15:0];
            2'b01: bcr_m = a[15:0];
            default: ;
          endcase
        end
        1: begin
          int c0; c0 = wr_cnt;
          bwrite(1'b0, 1'b0, a, d, 2'($urandom));
          chk("R6 rand pulse", wr_cnt - c0, 1);
          chk("R6 rand data", {16'd0, last_wd}, {16'd0, d});
        end
        2: arr_rd_chk("R7 rand", a);
        default: begin
          bread(1'b1, 1'b0, a, v, oe);
          case (a[19:18])
            2'b00: chk("R2 rand rcr", {16'd0, v}, {16'd0, rcr_m});
            2'b01: chk("R2 rand bcr", {16'd0, v}, {16'd0, bcr_m});
            default: chk("R3 rand rsvd", {16'd0, v}, 32'd0);
          endcase
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule